// File: doc/BRIEF.md
# USB Slave-FIFO Interface Bridge

This block is the FPGA-side master of the synchronous 16-bit FIFO port of an external USB peripheral controller. It connects that port to a 32-bit host bus that runs on its own clock. In the receive direction the block empties the controller's OUT endpoint FIFO. It joins each pair of 16-bit words into one 32-bit host word and places the result in a small dual-clock buffer, where the host pops it. In the transmit direction the host pushes 32-bit words into a second dual-clock buffer. The block sends each one to the IN endpoint FIFO as two 16-bit writes.

A port sequencer owns the external strobes and has six states:

- **IDLE**: the state after reset.
- **READ**: output enable is high, FIFO address `00`, and a read strobe is issued on every clock that has data and local room.
- **R2W**: the bus is idle for one cycle before the block drives it.
- **WRITE**: the bus is driven, FIFO address `10`, and a write strobe is issued on every clock that has a half-word pending and the full flag low.
- **W2R**: the bus is idle for one cycle before output enable rises.
- **COMMIT**: a one-clock packet-end strobe is issued.

The transitions are:

- IDLE goes to READ when there is read demand, or to WRITE when there is write or commit demand.
- READ goes to R2W when reading stalls and write or commit demand exists.
- WRITE goes to COMMIT when a commit is ready, or to W2R when writing stalls and read demand exists.
- R2W goes to WRITE, W2R goes to READ, and COMMIT returns to WRITE once the strobe is sent.

A one-cycle host request marks a short IN packet for commit. The commit is sent only after every earlier host word has left the port. All flags and strobes are active high.

Top module: `usbfb_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, if_rd, if_wr, if_oe, if_drive, if_pktend and h_rvalid are low and h_wready is high.
- R2: if_rd is high only while if_empty is low, if_oe is high and if_addr equals 2'b00.
- R3: With 16 half-words waiting in the OUT FIFO and room available, the block reads them on 16 consecutive interface clocks.
- R4: The first half-word read becomes bits [15:0] of a host word and the second becomes bits [31:16].
- R5: The receive buffer holds 8 host words. If the host does not pop, exactly 17 half-words are taken (8 words plus one held low half). Reading resumes once the host drains, and every word arrives in order.
- R6: if_wr is high only while if_full is low, if_drive is high and if_addr equals 2'b10.
- R7: Each host word leaves as two writes: bits [15:0] first, then bits [31:16].
- R8: When the host supplies 512 words without pause, the 1024 half-words are written on 1024 consecutive interface clocks.
- R9: if_oe and if_drive are never high in the same cycle or in adjacent cycles.
- R10: A packet-end request gives exactly one cycle of if_pktend, with if_addr 2'b10 and if_wr low. That cycle comes only after all host words pushed before the request have been written.
- R11: While if_full is high, a pending packet end is held back. It is issued after if_full falls.
- R12: While if_full is high no write occurs. When it falls, the queued half-words are written unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| if_clk | input | 1 | Interface clock of the external FIFO port |
| if_rst | input | 1 | Synchronous reset, interface domain, active high |
| if_din | input | 16 | Data from the OUT endpoint FIFO |
| if_dout | output | 16 | Data to the IN endpoint FIFO |
| if_drive | output | 1 | High when the block drives the data bus |
| if_empty | input | 1 | OUT endpoint empty flag, active high |
| if_full | input | 1 | IN endpoint full flag, active high |
| if_rd | output | 1 | Read strobe |
| if_wr | output | 1 | Write strobe |
| if_oe | output | 1 | Output enable for the controller's data drivers |
| if_pktend | output | 1 | Packet-end strobe, commits a short IN packet |
| if_addr | output | 2 | FIFO select: 00 OUT endpoint, 10 IN endpoint |
| h_clk | input | 1 | Host bus clock |
| h_rst | input | 1 | Synchronous reset, host domain, active high |
| h_wdata | input | 32 | Host word to transmit |
| h_wvalid | input | 1 | Host word valid |
| h_wready | output | 1 | Transmit buffer can accept a word |
| h_rdata | output | 32 | Received host word (head of buffer) |
| h_rvalid | output | 1 | Received word available |
| h_rready | input | 1 | Host pops the received word |
| h_pktend | input | 1 | One-cycle request to commit the IN packet |

## Verification
The hard coincidence is a packet-end request that arrives while earlier host words are still queued for the IN FIFO. The commit crosses the clock boundary on a path separate from the data. The bench pushes three words and pulses the request right after the last push. It then checks that the strobe lands just after the sixth half-word and lasts one cycle. The same request is also raised while the full flag is forced high, together with a stalled write stream, to show that the commit and the writes both wait and then drain in the right order.

// File: rtl/usbfb_pkg.sv
package usbfb_pkg;

    // Port sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_R2W,
        ST_WRITE,
        ST_W2R,
        ST_COMMIT
    } port_state_t;

    // FIFO select codes on the external port
    localparam logic [1:0] ADDR_OUT_EP = 2'b00;
    localparam logic [1:0] ADDR_IN_EP  = 2'b10;

endpackage

// File: rtl/usbfb_afifo.sv
// Dual-clock FIFO with Gray-coded pointers and show-ahead read data.
module usbfb_afifo #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         wen,
    input  logic [W-1:0] wdata,
    output logic         wfull,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         ren,
    output logic [W-1:0] rdata,
    output logic         rempty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, wbin_nx;
    logic [AW:0]  rbin, rgray, rbin_nx;
    logic [AW:0]  rq1, rq2, wq1, wq2;

    assign wbin_nx = wbin + {{AW{1'b0}}, 1'b1};
    assign rbin_nx = rbin + {{AW{1'b0}}, 1'b1};

    assign wfull  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign rempty = (rgray == wq2);
    assign rdata  = mem[rbin[AW-1:0]];

    always_ff @(posedge wclk) begin
        if (wen && !wfull) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    // write side pointers and read-pointer synchroniser
    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (wen && !wfull) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    // read side pointers and write-pointer synchroniser
    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            if (ren && !rempty) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
        end
    end

endmodule

// File: rtl/usbfb_pulse_xfer.sv
// Carries single-cycle requests from one clock domain to another by toggle.
module usbfb_pulse_xfer #(
    parameter int STAGES = 3
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    localparam int LAST = STAGES - 1;

    logic              tog;
    logic [STAGES-1:0] sync;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            tog <= 1'b0;
        end else if (src_pulse) begin
            tog <= ~tog;
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            sync <= '0;
        end else begin
            sync <= {sync[LAST-1:0], tog};
        end
    end

    assign dst_pulse = sync[LAST] ^ sync[LAST-1];

endmodule

// File: rtl/usbfb_rx_pack.sv
// Joins two consecutive half-words into one word, first half in the low bits.
module usbfb_rx_pack #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_fire,
    input  logic [HW-1:0] din,
    output logic          word_wen,
    output logic [2*HW-1:0] word_data,
    output logic          low_held
);
    logic [HW-1:0] low_q;
    logic          have_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q    <= '0;
            have_low <= 1'b0;
        end else if (rd_fire) begin
            if (!have_low) begin
                low_q <= din;
            end
            have_low <= ~have_low;
        end
    end

    assign word_wen  = rd_fire && have_low;
    assign word_data = {din, low_q};
    assign low_held  = have_low;

endmodule

// File: rtl/usbfb_tx_split.sv
// Holds one host word and presents it as two half-words, low half first.
module usbfb_tx_split #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fifo_empty,
    input  logic [2*HW-1:0] fifo_data,
    output logic            fifo_pop,
    input  logic            wr_fire,
    output logic            word_valid,
    output logic [HW-1:0]   dout
);
    logic [2*HW-1:0] word_q;
    logic            hi_sel;
    logic            valid_q;

    // refill when empty, or as the upper half leaves, so writes stay back to back
    assign fifo_pop = !fifo_empty && (!valid_q || (wr_fire && hi_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            hi_sel  <= 1'b0;
            valid_q <= 1'b0;
        end else if (fifo_pop) begin
            word_q  <= fifo_data;
            hi_sel  <= 1'b0;
            valid_q <= 1'b1;
        end else if (wr_fire) begin
            if (hi_sel) begin
                hi_sel  <= 1'b0;
                valid_q <= 1'b0;
            end else begin
                hi_sel <= 1'b1;
            end
        end
    end

    assign word_valid = valid_q;
    assign dout       = hi_sel ? word_q[2*HW-1:HW] : word_q[HW-1:0];

endmodule

// File: rtl/usbfb_port_fsm.sv
// Sequencer for the external port: direction, turnaround and strobes.
module usbfb_port_fsm
    import usbfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       read_want,
    input  logic       write_want,
    input  logic       commit_want,
    input  logic       full_flag,
    output logic       rd,
    output logic       wr,
    output logic       oe,
    output logic       drive,
    output logic       pktend,
    output logic [1:0] addr
);
    port_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (read_want) begin
                    state_nx = ST_READ;
                end else if (write_want || commit_want) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_READ: begin
                if (!read_want && (write_want || commit_want)) begin
                    state_nx = ST_R2W;
                end
            end
            ST_R2W:  state_nx = ST_WRITE;
            ST_WRITE: begin
                if (commit_want) begin
                    state_nx = ST_COMMIT;
                end else if (!write_want && read_want) begin
                    state_nx = ST_W2R;
                end
            end
            ST_W2R:  state_nx = ST_READ;
            ST_COMMIT: begin
                if (!full_flag) begin
                    state_nx = ST_WRITE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        rd     = 1'b0;
        wr     = 1'b0;
        oe     = 1'b0;
        drive  = 1'b0;
        pktend = 1'b0;
        addr   = ADDR_OUT_EP;
        unique case (state)
            ST_IDLE: ;
            ST_READ: begin
                oe = 1'b1;
                rd = read_want;
            end
            ST_R2W: addr = ADDR_IN_EP;
            ST_WRITE: begin
                drive = 1'b1;
                addr  = ADDR_IN_EP;
                wr    = write_want;
            end
            ST_W2R: ;
            ST_COMMIT: begin
                drive  = 1'b1;
                addr   = ADDR_IN_EP;
                pktend = !full_flag;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/usbfb_bridge.sv
// Top: 16-bit external FIFO port to 32-bit host bus, both directions.
module usbfb_bridge
    import usbfb_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int TX_AW  = 3,
    parameter int RX_AW  = 3,
    parameter int SYNC_N = 3
) (
    input  logic                if_clk,
    input  logic                if_rst,
    input  logic [HALF_W-1:0]   if_din,
    output logic [HALF_W-1:0]   if_dout,
    output logic                if_drive,
    input  logic                if_empty,
    input  logic                if_full,
    output logic                if_rd,
    output logic                if_wr,
    output logic                if_oe,
    output logic                if_pktend,
    output logic [1:0]          if_addr,
    input  logic                h_clk,
    input  logic                h_rst,
    input  logic [2*HALF_W-1:0] h_wdata,
    input  logic                h_wvalid,
    output logic                h_wready,
    output logic [2*HALF_W-1:0] h_rdata,
    output logic                h_rvalid,
    input  logic                h_rready,
    input  logic                h_pktend
);
    localparam int WORD_W = 2 * HALF_W;

    logic              tx_full, tx_empty, tx_pop;
    logic [WORD_W-1:0] tx_data;
    logic              rx_full, rx_empty, rx_wen;
    logic [WORD_W-1:0] rx_wdata;
    logic              low_held, split_valid;
    logic              pkt_pulse, pkt_pend;
    logic              read_want, write_want, commit_want;

    // host -> interface words
    usbfb_afifo #(.W(WORD_W), .AW(TX_AW)) u_txq (
        .wclk(h_clk), .wrst(h_rst), .wen(h_wvalid), .wdata(h_wdata), .wfull(tx_full),
        .rclk(if_clk), .rrst(if_rst), .ren(tx_pop), .rdata(tx_data), .rempty(tx_empty)
    );

    // interface -> host words
    usbfb_afifo #(.W(WORD_W), .AW(RX_AW)) u_rxq (
        .wclk(if_clk), .wrst(if_rst), .wen(rx_wen), .wdata(rx_wdata), .wfull(rx_full),
        .rclk(h_clk), .rrst(h_rst), .ren(h_rready), .rdata(h_rdata), .rempty(rx_empty)
    );

    assign h_wready = !tx_full;
    assign h_rvalid = !rx_empty;

    usbfb_pulse_xfer #(.STAGES(SYNC_N)) u_pkx (
        .src_clk(h_clk), .src_rst(h_rst), .src_pulse(h_pktend),
        .dst_clk(if_clk), .dst_rst(if_rst), .dst_pulse(pkt_pulse)
    );

    // a fresh request wins over the clear so back-to-back requests are kept
    always_ff @(posedge if_clk) begin
        if (if_rst) begin
            pkt_pend <= 1'b0;
        end else if (pkt_pulse) begin
            pkt_pend <= 1'b1;
        end else if (if_pktend) begin
            pkt_pend <= 1'b0;
        end
    end

    usbfb_rx_pack #(.HW(HALF_W)) u_pack (
        .clk(if_clk), .rst(if_rst), .rd_fire(if_rd), .din(if_din),
        .word_wen(rx_wen), .word_data(rx_wdata), .low_held(low_held)
    );

    usbfb_tx_split #(.HW(HALF_W)) u_split (
        .clk(if_clk), .rst(if_rst), .fifo_empty(tx_empty), .fifo_data(tx_data),
        .fifo_pop(tx_pop), .wr_fire(if_wr), .word_valid(split_valid), .dout(if_dout)
    );

    // a low half alone needs no buffer slot; completing a word does
    assign read_want   = !if_empty && (!low_held || !rx_full);
    assign write_want  = !if_full && split_valid;
    assign commit_want = pkt_pend && !split_valid && tx_empty && !if_full;

    usbfb_port_fsm u_fsm (
        .clk(if_clk), .rst(if_rst),
        .read_want(read_want), .write_want(write_want), .commit_want(commit_want),
        .full_flag(if_full),
        .rd(if_rd), .wr(if_wr), .oe(if_oe), .drive(if_drive),
        .pktend(if_pktend), .addr(if_addr)
    );

endmodule

// File: rtl/usbfb_checker.sv
module usbfb_checker (
    input logic       if_clk,
    input logic       if_rst,
    input logic       if_rd,
    input logic       if_wr,
    input logic       if_oe,
    input logic       if_drive,
    input logic       if_pktend,
    input logic       if_empty,
    input logic       if_full,
    input logic [1:0] if_addr
);
    p_rd_gate_r2: assert property (@(posedge if_clk) disable iff (if_rst)
        if_rd |-> (!if_empty && if_oe && if_addr == 2'b00));

    p_wr_gate_r6: assert property (@(posedge if_clk) disable iff (if_rst)
        if_wr |-> (!if_full && if_drive && if_addr == 2'b10));

    p_oe_then_idle_r9: assert property (@(posedge if_clk) disable iff (if_rst)
        if_oe |=> !if_drive);

    p_drive_then_idle_r9: assert property (@(posedge if_clk) disable iff (if_rst)
        if_drive |=> !if_oe);

    p_same_cycle_r9: assert property (@(posedge if_clk) disable iff (if_rst)
        !(if_oe && if_drive));

    p_pkt_single_r10: assert property (@(posedge if_clk) disable iff (if_rst)
        if_pktend |=> !if_pktend);

    p_strobe_excl_r10: assert property (@(posedge if_clk) disable iff (if_rst)
        $onehot0({if_rd, if_wr, if_pktend}));

    p_pkt_gate_r11: assert property (@(posedge if_clk) disable iff (if_rst)
        if_pktend |-> (!if_full && if_addr == 2'b10));

endmodule

bind usbfb_bridge usbfb_checker u_chk (
    .if_clk(if_clk), .if_rst(if_rst), .if_rd(if_rd), .if_wr(if_wr),
    .if_oe(if_oe), .if_drive(if_drive), .if_pktend(if_pktend),
    .if_empty(if_empty), .if_full(if_full), .if_addr(if_addr)
);

// File: tb/sim_usbfb_bridge.sv
`timescale 1ns/1ps
module sim_usbfb_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] if_din;
    logic [15:0] if_dout;
    logic        if_drive, if_rd, if_wr, if_oe, if_pktend;
    logic [1:0]  if_addr;
    logic        if_empty;
    logic        full_force = 1'b0;
    logic [31:0] h_wdata = '0;
    logic        h_wvalid = 1'b0, h_wready;
    logic [31:0] h_rdata;
    logic        h_rvalid, h_rready = 1'b0;
    logic        h_pktend = 1'b0;

    always #10 clk = ~clk;

    // external controller model
    logic [15:0] out_mem [256];
    int          out_idx = 0, out_cnt = 0;
    logic [15:0] in_cap [2048];
    int          wr_cyc [2048];
    int          rd_cyc [128];
    int          in_n = 0, rd_n = 0, pk_n = 0, pk_at = 0, cyc = 0;
    int          rd_bad = 0, wr_bad = 0, turn_bad = 0, pk_bad = 0, oe_rise = 0;
    logic        prev_oe = 1'b0, prev_drv = 1'b0, prev_pk = 1'b0;

    assign if_din   = out_mem[out_idx[7:0]];
    assign if_empty = (out_idx == out_cnt);

    usbfb_bridge u0 (
        .if_clk(clk), .if_rst(rst), .if_din(if_din), .if_dout(if_dout),
        .if_drive(if_drive), .if_empty(if_empty), .if_full(full_force),
        .if_rd(if_rd), .if_wr(if_wr), .if_oe(if_oe), .if_pktend(if_pktend),
        .if_addr(if_addr), .h_clk(clk), .h_rst(rst), .h_wdata(h_wdata),
        .h_wvalid(h_wvalid), .h_wready(h_wready), .h_rdata(h_rdata),
        .h_rvalid(h_rvalid), .h_rready(h_rready), .h_pktend(h_pktend)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (if_rd) begin
                out_idx <= out_idx + 1;
                rd_cyc[rd_n] <= cyc;
                rd_n <= rd_n + 1;
            end
            if (if_wr) begin
                in_cap[in_n] <= if_dout;
                wr_cyc[in_n] <= cyc;
                in_n <= in_n + 1;
            end
            if (if_pktend) begin
                pk_n  <= pk_n + 1;
                pk_at <= in_n;
            end
            if (if_rd && (if_empty || !if_oe || if_addr != 2'b00)) rd_bad <= rd_bad + 1;
            if (if_wr && (full_force || !if_drive || if_addr != 2'b10)) wr_bad <= wr_bad + 1;
            if ((if_drive && (prev_oe || if_oe)) || (if_oe && prev_drv)) turn_bad <= turn_bad + 1;
            if (if_pktend && (prev_pk || if_wr || if_addr != 2'b10)) pk_bad <= pk_bad + 1;
            if (if_oe && !prev_oe) oe_rise <= oe_rise + 1;
            prev_oe  <= if_oe;
            prev_drv <= if_drive;
            prev_pk  <= if_pktend;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0] tx_q [512];
    logic [31:0] rx_got [32];

    task automatic push_words(input int n);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            if (h_wready) begin
                h_wdata  = tx_q[i];
                h_wvalid = 1'b1;
                i++;
            end else begin
                h_wvalid = 1'b0;
            end
        end
        @(negedge clk);
        h_wvalid = 1'b0;
    endtask

    task automatic pop_words(input int n);
        int got = 0;
        int g = 0;
        while (got < n && g < 3000) begin
            @(negedge clk);
            g++;
            if (h_rvalid) begin
                rx_got[got] = h_rdata;
                got++;
                h_rready = 1'b1;
            end else begin
                h_rready = 1'b0;
            end
        end
        @(negedge clk);
        h_rready = 1'b0;
    endtask

    task automatic pulse_pkt();
        @(negedge clk);
        h_pktend = 1'b1;
        @(negedge clk);
        h_pktend = 1'b0;
    endtask

    task automatic wait_in(input int target);
        int g = 0;
        while (in_n < target && g < 3000) begin
            @(negedge clk);
            g++;
        end
    endtask

    // {host word, expected first half, expected second half}
    localparam logic [63:0] VEC [8] = '{
        64'h12345678_5678_1234,
        64'hDEADBEEF_BEEF_DEAD,
        64'h0000FFFF_FFFF_0000,
        64'hFFFF0000_0000_FFFF,
        64'hA5A55A5A_5A5A_A5A5,
        64'h00000001_0001_0000,
        64'h80000000_0000_8000,
        64'hCAFEF00D_F00D_CAFE
    };

    initial begin
        int base;
        int rbase;
        int pk0;
        int errs;

        // reset state
        repeat (4) @(negedge clk);
        chk("R1 strobes in reset", {if_rd, if_wr, if_oe, if_drive, if_pktend, h_rvalid, h_wready}, 7'b0000001);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes after reset", {if_rd, if_wr, if_oe, if_drive, if_pktend, h_rvalid, h_wready}, 7'b0000001);

        // vector table: split order
        base = in_n;
        for (int v = 0; v < 8; v++) tx_q[v] = VEC[v][63:32];
        push_words(8);
        wait_in(base + 16);
        for (int v = 0; v < 8; v++) begin
            chk("R7 first half", in_cap[base + 2*v], VEC[v][31:16]);
            chk("R7 second half", in_cap[base + 2*v + 1], VEC[v][15:0]);
        end

        // sustained read and packing
        rbase = rd_n;
        for (int i = 0; i < 16; i++) out_mem[(out_cnt + i) % 256] = 16'hA000 + 16'(i);
        @(negedge clk);
        out_cnt = out_cnt + 16;
        repeat (40) @(negedge clk);
        chk("R3 reads taken", rd_n - rbase, 16);
        chk("R3 consecutive reads", rd_cyc[rbase + 15] - rd_cyc[rbase] + 1, 16);
        pop_words(8);
        errs = 0;
        for (int i = 0; i < 8; i++)
            if (rx_got[i] != {16'hA000 + 16'(2*i + 1), 16'hA000 + 16'(2*i)}) errs++;
        chk("R4 packed word order", errs, 0);
        chk("R4 first word", rx_got[0], 32'hA001A000);
        chk("R2 read gating", rd_bad, 0);
        chk("R9 switch seen", oe_rise > 0, 1);

        // receive back-pressure
        rbase = rd_n;
        for (int i = 0; i < 40; i++) out_mem[(out_cnt + i) % 256] = 16'hB000 + 16'(i);
        @(negedge clk);
        out_cnt = out_cnt + 40;
        repeat (100) @(negedge clk);
        chk("R5 reads while host stalled", rd_n - rbase, 17);
        pop_words(20);
        errs = 0;
        for (int i = 0; i < 20; i++)
            if (rx_got[i] != {16'hB000 + 16'(2*i + 1), 16'hB000 + 16'(2*i)}) errs++;
        chk("R5 data after drain", errs, 0);
        chk("R5 all reads done", rd_n - rbase, 40);

        // full flag stall
        full_force = 1'b1;
        base = in_n;
        for (int i = 0; i < 4; i++) tx_q[i] = {16'hC000 + 16'(2*i + 1), 16'hC000 + 16'(2*i)};
        push_words(4);
        repeat (30) @(negedge clk);
        chk("R12 no write while full", in_n - base, 0);
        full_force = 1'b0;
        wait_in(base + 8);
        errs = 0;
        for (int i = 0; i < 8; i++) if (in_cap[base + i] != 16'hC000 + 16'(i)) errs++;
        chk("R12 data after release", errs, 0);
        chk("R6 write gating", wr_bad, 0);

        // packet end behind queued data
        base = in_n;
        pk0  = pk_n;
        for (int i = 0; i < 3; i++) tx_q[i] = {16'hD000 + 16'(2*i + 1), 16'hD000 + 16'(2*i)};
        push_words(3);
        pulse_pkt();
        repeat (40) @(negedge clk);
        chk("R10 one commit", pk_n - pk0, 1);
        chk("R10 commit after all halves", pk_at - base, 6);
        chk("R10 strobe shape", pk_bad, 0);

        // packet end held by full flag
        full_force = 1'b1;
        pk0 = pk_n;
        pulse_pkt();
        repeat (30) @(negedge clk);
        chk("R11 held while full", pk_n - pk0, 0);
        full_force = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 issued after release", pk_n - pk0, 1);

        // continuous burst of 2048 bytes
        base = in_n;
        for (int i = 0; i < 512; i++) tx_q[i] = {16'h1000 + 16'(2*i + 1), 16'h1000 + 16'(2*i)};
        push_words(512);
        wait_in(base + 1024);
        chk("R8 half-words written", in_n - base, 1024);
        chk("R8 consecutive writes", wr_cyc[base + 1023] - wr_cyc[base] + 1, 1024);
        errs = 0;
        for (int i = 0; i < 1024; i++) if (in_cap[base + i] != 16'h1000 + 16'(i)) errs++;
        chk("R8 burst data", errs, 0);
        chk("R9 turnaround", turn_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule